// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the command front end of a parallel NOR flash model that follows the widely used 0x20/0x40/0x70/0x90/0x98 command set. Bus writes deliver an address and a data word on a single strobe. In the idle phase the low byte of the data is decoded as a command, and a small phase counter walks the multi-cycle sequences: program, sector erase, lock/unlock, query and buffered write. Every operation finishes in the clock edge on which it is issued, so the ready bit of the status byte is set in that same edge.

An 8-bit status register collects the ready flag and the error flags. The current command selects what a bus read returns. This is either the storage array, the status byte copied into every device lane, the identifier words, or the query table. A write-protect input keeps the storage intact and raises the matching error flag instead.

Top module: `nor_cmd_engine`

## Requirements
- R1: After synchronous reset the phase is idle, the command is cleared and the status byte is 0x00, so reads return array words and a read-status command then returns 0x00 in every lane.
- R2: In the idle phase, the command bytes 0xFF, 0xF0 and 0x00, and any byte that is not a supported command, put the block back in array-read mode.
- R3: Byte 0x10 or 0x40 arms a program. The next write stores its data word at its own address, sets status bit 7 and returns to the idle phase, while reads keep returning status.
- R4: Byte 0x20 erases at once. It writes all-ones to every word of the sector that contains the address (SECTOR_WORDS words, address aligned down) and sets status bit 7.
- R5: After 0x20 the next write must be 0xD0, which returns to idle with bit 7 set and reads still on status, or 0xFF, which returns to array read. Any other byte returns to array read.
- R6: While wp is high, the storage is not changed. An erase sets status bit 5 and a program or buffered data word sets status bit 4, and bit 7 is set in both cases.
- R7: Byte 0x50 clears the whole status byte to 0x00 and returns to array read.
- R8: Byte 0x60 followed by 0xD0 or 0x01 sets status bit 7 and keeps reads on status. Any other second byte returns to array read.
- R9: Bytes 0x70 and 0x90 switch the read mode without leaving the idle phase, so the next write is decoded as a command. In 0x90 mode, word address 0 reads MFR_ID, word address 1 reads DEV_ID and any other address reads 0, each copied into every lane.
- R10: Byte 0xE8 sets bit 7 and starts a buffered write. The next word gives a count masked to DEV_W bits. Then count+1 data words are stored at their own addresses, and after them 0xD0 completes with bit 7 set. Any other byte returns to array read.
- R11: While the command is 0x10, 0x20, 0x40, 0x60, 0x70 or 0xE8, reads return the status byte in every DEV_W lane.
- R12: Byte 0x98 enters query mode, where offsets 0x10..0x13 read 0x51, 0x52, 0x59, 0x01 and other offsets read 0, per lane. A later write of 0xFF leaves the mode, and any other byte leaves it in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data; low byte carries commands |
| wp | input | 1 | Write protect, blocks storage changes |
| rd_data | output | DATA_W | Read data for the current address and mode |

## Verification
On every cycle, assertions check the following. Ready follows a program. Protected programs and erases raise their error flags. Clear empties the status byte. The 0x70/0x90 commands leave the phase idle. The confirm phase belongs only to a buffered write. An erased sector base word is all ones. Only the bench scenarios can show the full effect on the storage: sector alignment across a complete sweep, untouched neighbours, the count mask of the buffered write, lane copying of status, identifier and query values, and the return to array reads after error bytes.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam logic [7:0] C_RESET0  = 8'h00;
    localparam logic [7:0] C_PROG_A  = 8'h10;
    localparam logic [7:0] C_ERASE   = 8'h20;
    localparam logic [7:0] C_ERASE_B = 8'h28;
    localparam logic [7:0] C_PROG_B  = 8'h40;
    localparam logic [7:0] C_CLRST   = 8'h50;
    localparam logic [7:0] C_LOCK    = 8'h60;
    localparam logic [7:0] C_RDSTAT  = 8'h70;
    localparam logic [7:0] C_RDID    = 8'h90;
    localparam logic [7:0] C_QUERY   = 8'h98;
    localparam logic [7:0] C_CONFIRM = 8'hD0;
    localparam logic [7:0] C_BUFWR   = 8'hE8;
    localparam logic [7:0] C_RESET1  = 8'hF0;
    localparam logic [7:0] C_RESET2  = 8'hFF;
    localparam logic [7:0] C_UNLOCK  = 8'h01;

    localparam int ST_READY = 7;
    localparam int ST_ERERR = 5;
    localparam int ST_PGERR = 4;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ARMED   = 2'd1,
        PH_DATA    = 2'd2,
        PH_CONFIRM = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } store_op_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2,
        RD_QUERY  = 2'd3
    } rd_sel_e;

    typedef struct packed {
        phase_e     ph;
        logic [7:0] cmd;
        logic [7:0] st;
    } seq_state_t;

    function automatic rd_sel_e rd_sel_of(input logic [7:0] cmd);
        case (cmd)
            C_PROG_A, C_ERASE, C_ERASE_B, C_PROG_B,
            C_CLRST, C_LOCK, C_RDSTAT, C_BUFWR: return RD_STATUS;
            C_RDID:  return RD_IDENT;
            C_QUERY: return RD_QUERY;
            default: return RD_ARRAY;
        endcase
    endfunction

    function automatic logic [7:0] query_byte(input logic [7:0] off);
        case (off)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            8'h13:   return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int DEV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DEV_W-1:0] data_i,
    input  logic             wp,
    output store_op_e        op_o,
    output logic [7:0]       cmd_o,
    output logic [7:0]       st_o
);

    seq_state_t      cur_q, nxt;
    logic [DEV_W-1:0] cnt_q, cnt_n;
    logic [7:0]       byte_w;

    assign byte_w = data_i[7:0];

    always_comb begin
        nxt   = cur_q;
        cnt_n = cnt_q;
        op_o  = OP_NONE;
        if (wr_en) begin
            case (cur_q.ph)
                PH_IDLE: begin
                    case (byte_w)
                        C_PROG_A, C_PROG_B, C_LOCK, C_QUERY: begin
                            nxt.ph  = PH_ARMED;
                            nxt.cmd = byte_w;
                        end
                        C_ERASE: begin
                            if (wp) nxt.st[ST_ERERR] = 1'b1;
                            else    op_o = OP_ERASE;
                            nxt.st[ST_READY] = 1'b1;
                            nxt.ph  = PH_ARMED;
                            nxt.cmd = byte_w;
                        end
                        C_CLRST: begin
                            nxt.st  = 8'h00;
                            nxt.ph  = PH_IDLE;
                            nxt.cmd = C_RESET0;
                        end
                        C_RDSTAT, C_RDID: nxt.cmd = byte_w;
                        C_BUFWR: begin
                            nxt.st[ST_READY] = 1'b1;
                            nxt.ph  = PH_ARMED;
                            nxt.cmd = byte_w;
                        end
                        default: begin
                            nxt.ph  = PH_IDLE;
                            nxt.cmd = C_RESET0;
                        end
                    endcase
                end
                PH_ARMED: begin
                    case (cur_q.cmd)
                        C_PROG_A, C_PROG_B: begin
                            if (wp) nxt.st[ST_PGERR] = 1'b1;
                            else    op_o = OP_PROG;
                            nxt.st[ST_READY] = 1'b1;
                            nxt.ph = PH_IDLE;
                        end
                        C_ERASE, C_ERASE_B, C_LOCK: begin
                            if (byte_w == C_CONFIRM ||
                                (cur_q.cmd == C_LOCK && byte_w == C_UNLOCK)) begin
                                nxt.st[ST_READY] = 1'b1;
                                nxt.ph = PH_IDLE;
                            end else begin
                                nxt.ph  = PH_IDLE;
                                nxt.cmd = C_RESET0;
                            end
                        end
                        C_BUFWR: begin
                            cnt_n  = data_i;
                            nxt.ph = PH_DATA;
                        end
                        C_QUERY: begin
                            if (byte_w == C_RESET2) begin
                                nxt.ph  = PH_IDLE;
                                nxt.cmd = C_RESET0;
                            end
                        end
                        default: begin
                            nxt.ph  = PH_IDLE;
                            nxt.cmd = C_RESET0;
                        end
                    endcase
                end
                PH_DATA: begin
                    if (cur_q.cmd == C_BUFWR) begin
                        if (wp) nxt.st[ST_PGERR] = 1'b1;
                        else    op_o = OP_PROG;
                        nxt.st[ST_READY] = 1'b1;
                        if (cnt_q == '0) nxt.ph = PH_CONFIRM;
                        cnt_n = cnt_q - 1'b1;
                    end else begin
                        nxt.ph  = PH_IDLE;
                        nxt.cmd = C_RESET0;
                    end
                end
                default: begin
                    if (cur_q.cmd == C_BUFWR && byte_w == C_CONFIRM) begin
                        nxt.st[ST_READY] = 1'b1;
                        nxt.ph = PH_IDLE;
                    end else begin
                        nxt.ph  = PH_IDLE;
                        nxt.cmd = C_RESET0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{ph: PH_IDLE, cmd: 8'h00, st: 8'h00};
            cnt_q <= '0;
        end else begin
            cur_q <= nxt;
            cnt_q <= cnt_n;
        end
    end

    assign cmd_o = cur_q.cmd;
    assign st_o  = cur_q.st;

    assert_prog_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur_q.ph == PH_ARMED && (cur_q.cmd == C_PROG_A || cur_q.cmd == C_PROG_B))
        |=> (cur_q.st[ST_READY] && cur_q.ph == PH_IDLE));

    assert_wp_prog_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wp && cur_q.ph == PH_ARMED && (cur_q.cmd == C_PROG_A || cur_q.cmd == C_PROG_B))
        |=> cur_q.st[ST_PGERR]);

    assert_wp_erase_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wp && cur_q.ph == PH_IDLE && byte_w == C_ERASE)
        |=> (cur_q.st[ST_ERERR] && cur_q.st[ST_READY]));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur_q.ph == PH_IDLE && byte_w == C_CLRST)
        |=> (cur_q.st == 8'h00 && cur_q.cmd == C_RESET0));

    assert_mode_no_advance_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur_q.ph == PH_IDLE && (byte_w == C_RDSTAT || byte_w == C_RDID))
        |=> (cur_q.ph == PH_IDLE && cur_q.cmd == $past(byte_w)));

    assert_confirm_owner_R10: assert property (@(posedge clk) disable iff (rst)
        (cur_q.ph == PH_CONFIRM || cur_q.ph == PH_DATA) |-> cur_q.cmd == C_BUFWR);

endmodule

// File: rtl/nor_word_store.sv
module nor_word_store
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 16,
    parameter int SECTOR_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  store_op_e         op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int SEC_LOG = $clog2(SECTOR_WORDS);
    localparam int SEC_W   = ADDR_W - SEC_LOG;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [SEC_W-1:0]  sec_sel;

    assign sec_sel = addr_i[ADDR_W-1:SEC_LOG];

    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (op_i == OP_ERASE && SEC_W'(w >> SEC_LOG) == sec_sel)
                mem_q[w] <= '1;
            else if (op_i == OP_PROG && ADDR_W'(w) == addr_i)
                mem_q[w] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

    assert_erase_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ERASE) |=> mem_q[{$past(sec_sel), {SEC_LOG{1'b0}}}] == '1);

endmodule

// File: rtl/nor_read_steer.sv
module nor_read_steer
    import nor_cmd_pkg::*;
#(
    parameter int              ADDR_W = 6,
    parameter int              DATA_W = 16,
    parameter int              DEV_W  = 8,
    parameter logic [DEV_W-1:0] MFR_ID = 'h89,
    parameter logic [DEV_W-1:0] DEV_ID = 'h18
) (
    input  rd_sel_e           sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        st_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rd_o
);

    localparam int LANES = DATA_W / DEV_W;
    localparam int OFF_W = (ADDR_W < 8) ? ADDR_W : 8;

    logic [7:0]       off;
    logic [DEV_W-1:0] lane_val;

    assign off = 8'(addr_i[OFF_W-1:0]);

    always_comb begin
        case (sel_i)
            RD_STATUS: lane_val = DEV_W'(st_i);
            RD_IDENT: begin
                if (addr_i == ADDR_W'(0))      lane_val = MFR_ID;
                else if (addr_i == ADDR_W'(1)) lane_val = DEV_ID;
                else                           lane_val = '0;
            end
            RD_QUERY: lane_val = DEV_W'(query_byte(off));
            default:  lane_val = '0;
        endcase
    end

    logic [DATA_W-1:0] lanes_w;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lanes_w[l*DEV_W +: DEV_W] = lane_val;
    end

    assign rd_o = (sel_i == RD_ARRAY) ? array_i : lanes_w;

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
    import nor_cmd_pkg::*;
#(
    parameter int              ADDR_W       = 6,
    parameter int              DATA_W       = 16,
    parameter int              DEV_W        = 8,
    parameter int              SECTOR_WORDS = 8,
    parameter logic [DEV_W-1:0] MFR_ID       = 'h89,
    parameter logic [DEV_W-1:0] DEV_ID       = 'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wp,
    output logic [DATA_W-1:0] rd_data
);

    store_op_e         op_w;
    logic [7:0]        cmd_w;
    logic [7:0]        st_w;
    logic [DATA_W-1:0] array_w;

    nor_cmd_seq #(.DEV_W(DEV_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .data_i (wdata[DEV_W-1:0]),
        .wp     (wp),
        .op_o   (op_w),
        .cmd_o  (cmd_w),
        .st_o   (st_w)
    );

    nor_word_store #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .SECTOR_WORDS (SECTOR_WORDS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op_w),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (array_w)
    );

    nor_read_steer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEV_W  (DEV_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_steer (
        .sel_i   (rd_sel_of(cmd_w)),
        .addr_i  (addr),
        .st_i    (st_w),
        .array_i (array_w),
        .rd_o    (rd_data)
    );

    assert_wp_no_store_R6: assert property (@(posedge clk) disable iff (rst)
        wp |-> op_w == OP_NONE);

endmodule

// File: tb/nor_cmd_engine_bench.sv
module nor_cmd_engine_bench;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NW = 1 << AW;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wp = 1'b0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [NW];

    always #5 clk = ~clk;

    nor_cmd_engine u_nor_cmd_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .wp(wp), .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 16'h0357) ^ 16'hA5C3);
    endfunction

    task automatic bus_wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [DW-1:0] exp);
        addr = AW'(a);
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr %0d got %h exp %h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: status zero after reset
        bus_wr(0, 16'h0070);
        rd_chk("R1", 0, 16'h0000);
        bus_wr(0, 16'h00FF);

        // R4: erase every sector, confirm each
        for (int s = 0; s < NW / SW; s++) begin
            bus_wr(s * SW + 3, 16'h0020);
            rd_chk("R11", s * SW, 16'h8080);
            bus_wr(s * SW + 3, 16'h00D0);
            rd_chk("R5", s * SW, 16'h8080);
        end
        bus_wr(0, 16'h00FF);
        for (int i = 0; i < NW; i++) begin
            model[i] = 16'hFFFF;
            rd_chk("R4", i, 16'hFFFF);
        end

        // R7: clear status returns to array
        bus_wr(0, 16'h0050);
        rd_chk("R7", 5, 16'hFFFF);
        bus_wr(0, 16'h0070);
        rd_chk("R7", 5, 16'h0000);

        // R3: program sweep with both opcodes
        for (int i = 0; i < NW; i++) begin
            bus_wr(i, (i % 2 == 0) ? 16'h0040 : 16'h0010);
            bus_wr(i, pat(i));
            model[i] = pat(i);
            rd_chk("R11", i, 16'h8080);
        end
        bus_wr(0, 16'h00FF);
        for (int i = 0; i < NW; i++) rd_chk("R3", i, model[i]);

        // R4: aligned erase of sector 2 via address 21
        bus_wr(21, 16'h0020);
        bus_wr(21, 16'h00D0);
        bus_wr(0, 16'h00FF);
        for (int i = 16; i < 24; i++) model[i] = 16'hFFFF;
        for (int i = 8; i < 32; i++) rd_chk("R4", i, model[i]);

        // R5: bad follow-up byte and 0xFF return to array
        bus_wr(40, 16'h0020);
        for (int i = 40; i < 48; i++) model[i] = 16'hFFFF;
        bus_wr(40, 16'h0033);
        rd_chk("R5", 40, 16'hFFFF);
        rd_chk("R5", 39, model[39]);
        bus_wr(50, 16'h0020);
        bus_wr(50, 16'h00FF);
        for (int i = 48; i < 56; i++) model[i] = 16'hFFFF;
        rd_chk("R5", 50, 16'hFFFF);

        // R6: write protect
        bus_wr(0, 16'h0050);
        wp = 1'b1;
        bus_wr(1, 16'h0040);
        bus_wr(1, 16'hBEEF);
        rd_chk("R6", 1, 16'h9090);
        bus_wr(0, 16'h00FF);
        rd_chk("R6", 1, model[1]);
        bus_wr(0, 16'h0050);
        bus_wr(8, 16'h0020);
        rd_chk("R6", 8, 16'hA0A0);
        bus_wr(8, 16'h00D0);
        bus_wr(0, 16'h00FF);
        for (int i = 8; i < 16; i++) rd_chk("R6", i, model[i]);
        wp = 1'b0;

        // R8: lock/unlock
        bus_wr(0, 16'h0050);
        bus_wr(4, 16'h0060);
        bus_wr(4, 16'h0001);
        rd_chk("R8", 4, 16'h8080);
        bus_wr(0, 16'h0050);
        bus_wr(4, 16'h0060);
        bus_wr(4, 16'h00D0);
        rd_chk("R8", 4, 16'h8080);
        bus_wr(0, 16'h0050);
        bus_wr(4, 16'h0060);
        bus_wr(4, 16'h0077);
        rd_chk("R8", 4, model[4]);

        // R9: identifier read and no phase advance
        bus_wr(0, 16'h0090);
        rd_chk("R9", 0, 16'h8989);
        rd_chk("R9", 1, 16'h1818);
        rd_chk("R9", 5, 16'h0000);
        bus_wr(3, 16'h0040);
        bus_wr(3, 16'h1111);
        model[3] = 16'h1111;
        bus_wr(0, 16'h00FF);
        rd_chk("R9", 3, 16'h1111);

        // R12: query mode
        bus_wr(0, 16'h0098);
        rd_chk("R12", 16, 16'h5151);
        rd_chk("R12", 17, 16'h5252);
        rd_chk("R12", 18, 16'h5959);
        rd_chk("R12", 19, 16'h0101);
        rd_chk("R12", 0, 16'h0000);
        bus_wr(0, 16'h0040);
        rd_chk("R12", 16, 16'h5151);
        bus_wr(0, 16'h00FF);
        rd_chk("R12", 16, model[16]);

        // R10: buffered write, count masked to 3 -> 4 words
        bus_wr(0, 16'h0050);
        bus_wr(32, 16'h00E8);
        rd_chk("R10", 32, 16'h8080);
        bus_wr(32, 16'h0103);
        for (int k = 0; k < 4; k++) begin
            bus_wr(32 + k, 16'hC000 + DW'(k));
            model[32 + k] = 16'hC000 + DW'(k);
        end
        bus_wr(32, 16'h00D0);
        rd_chk("R10", 32, 16'h8080);
        bus_wr(0, 16'h00FF);
        for (int i = 32; i < 37; i++) rd_chk("R10", i, model[i]);
        bus_wr(48, 16'h00E8);
        bus_wr(48, 16'h0000);
        bus_wr(48, 16'h7777);
        model[48] = 16'h7777;
        bus_wr(48, 16'h0055);
        rd_chk("R10", 48, 16'h7777);

        // R2: return-to-array bytes and unknown command
        bus_wr(0, 16'h0070);
        bus_wr(0, 16'h0033);
        rd_chk("R2", 2, model[2]);
        bus_wr(0, 16'h0070);
        bus_wr(0, 16'h00F0);
        rd_chk("R2", 2, model[2]);
        bus_wr(0, 16'h0070);
        bus_wr(0, 16'h0000);
        rd_chk("R2", 2, model[2]);

        // R1: reset mid-sequence returns to array
        bus_wr(3, 16'h0040);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R1", 3, model[3]);
        bus_wr(0, 16'h0070);
        rd_chk("R1", 0, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule